// File: doc/BRIEF.md
# Multi-Mode Host Bus Register Front End

This block puts a small 8-bit register file behind any one of four host bus styles. The bus style is fixed by straps. A 4-bit select strap, the ALE pin level and a multiplex strap choose the style at board level. In PC I/O mode the block answers a pair of adjacent port addresses. The odd port holds a register index. The even port moves data to and from the register that the index selects.

In the three microcontroller styles, the low eight address lines name the register directly. The three styles are:
- Motorola-style strobes.
- Intel-style strobes with separate address and data lines.
- Intel-style strobes with address and data multiplexed on one set of lines. Here an ALE pulse latches the address.

Host strobes are sampled by the core clock. A write is committed one clock after its strobe deasserts. Reads are combinational, and they drive the output enable of an external tri-state data buffer.

Top module: `hostbus_frontend`

## Requirements
- R1: The straps select the mode as follows. A nonzero `iosel` selects PC I/O mode, and microcontroller strobes are then ignored. With `iosel`=0000, `mux_mode`=1 selects multiplexed Intel mode. With `iosel`=0000 and `mux_mode`=0, `ale`=1 selects Motorola mode and `ale`=0 selects separate-bus Intel mode. In microcontroller modes the PC strobes `ior_n` and `iow_n` are ignored.
- R2: In PC I/O mode an access is taken only when `sa[9:1]` equals `BASE_ADDR[9:1]`. Any other address gives no output enable and changes no state.
- R3: In PC I/O mode an access with `sa[0]`=1 writes or reads the 8-bit index register.
- R4: In PC I/O mode an access with `sa[0]`=0 writes or reads the register whose number is held in the index register.
- R5: In Motorola mode the conditions are as follows. A read is `cs_n`=0, `ds_n`=0 and `rw`=1. A write is `cs_n`=0, `ds_n`=0 and `rw`=0. The register address is `sa[7:0]`.
- R6: In separate-bus Intel mode the conditions are as follows. A read is `cs_n`=0 with `rd_n`=0. A write is `cs_n`=0 with `wr_n`=0. The register address is the live `sa[7:0]`. With `cs_n`=1 nothing happens.
- R7: In multiplexed mode `sa[7:0]` is captured on every clock while `ale`=1. The captured value is then held as the register address after `ale` falls, even when the shared lines carry data.
- R8: A write changes state on the first clock edge at which the write strobe is seen inactive. It uses the address and data present in the last clock of the active strobe.
- R9: `bd_oe` is 1 only during an active read, and `bd_out` is 0 whenever `bd_oe` is 0.
- R10: After reset the index register and every register hold 0.
- R11: A register address with any bit at or above `REG_AW` set is out of range. Writes to it are dropped, and reads from it return 0. This holds both for a direct address and for the PC index.
- R12: In PC I/O mode, `ior_n` and `iow_n` low together is not an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iosel | input | 4 | Mode / PC select strap |
| ale | input | 1 | Motorola strap level, or address latch pulse in multiplexed mode |
| mux_mode | input | 1 | Strap: multiplexed address/data Intel bus |
| sa | input | 10 | Host address lines |
| ior_n | input | 1 | PC I/O read strobe |
| iow_n | input | 1 | PC I/O write strobe |
| cs_n | input | 1 | Microcontroller chip select |
| rd_n | input | 1 | Intel read strobe |
| wr_n | input | 1 | Intel write strobe |
| rw | input | 1 | Motorola read/not-write |
| ds_n | input | 1 | Motorola data strobe |
| bd_in | input | 8 | Data from host bus |
| bd_out | output | 8 | Data to host bus |
| bd_oe | output | 1 | Data buffer output enable |

## Verification
The hardest case to reach is the multiplexed-mode write. The address must survive the fall of `ale`, and the shared lines then carry the data value. The stimulus copies the data byte onto `sa[7:0]` after the ALE pulse, exactly as the board wiring would. It then reads the register back through a fresh ALE cycle.

A second hard case is a data change partway through a long write strobe. It shows that the committed byte is the last one seen, and that the commit happens one edge after deassertion. The bench steers the PC index out of range, sends writes to a neighbouring port pair, and asserts both PC strobes at once. After each of these it reads back the untouched registers.

// File: rtl/hostbus_frontend.sv
module hostbus_frontend #(
  parameter logic [9:0] BASE_ADDR = 10'h2E0,
  parameter int         REG_AW    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] iosel,
  input  logic       ale,
  input  logic       mux_mode,
  input  logic [9:0] sa,
  input  logic       ior_n,
  input  logic       iow_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       rw,
  input  logic       ds_n,
  input  logic [7:0] bd_in,
  output logic [7:0] bd_out,
  output logic       bd_oe
);
  localparam int NREG = 1 << REG_AW;
  localparam logic [8:0] BASE_HI = BASE_ADDR[9:1];

  logic [NREG-1:0][7:0] rf;
  logic [7:0] idx, mux_addr, cap_addr, cap_data;
  logic       wr_q, cap_index;

  wire pc_mode  = |iosel;
  wire mux_sel  = !pc_mode && mux_mode;
  wire moto_sel = !pc_mode && !mux_mode && ale;
  wire pc_hit   = sa[9:1] == BASE_HI;

  wire pc_rd  = pc_mode && pc_hit && !ior_n && iow_n;
  wire pc_wr  = pc_mode && pc_hit && !iow_n && ior_n;
  wire mc_rd  = !pc_mode && !cs_n && (moto_sel ? (!ds_n && rw)  : (!rd_n && wr_n));
  wire mc_wr  = !pc_mode && !cs_n && (moto_sel ? (!ds_n && !rw) : (!wr_n && rd_n));
  wire rd_act = pc_rd || mc_rd;
  wire wr_act = pc_wr || mc_wr;

  wire [7:0] acc_addr = pc_mode ? idx : (mux_sel ? mux_addr : sa[7:0]);
  wire       to_index = pc_mode && sa[0];
  wire       in_range = (acc_addr >> REG_AW) == 8'd0;
  wire [7:0] rd_data  = to_index ? idx :
                        (in_range ? rf[acc_addr[REG_AW-1:0]] : 8'd0);
  wire       commit   = wr_q && !wr_act;
  wire       cap_ok   = (cap_addr >> REG_AW) == 8'd0;

  assign bd_oe  = rd_act;
  assign bd_out = rd_act ? rd_data : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_addr <= '0;
    end else if (mux_sel && ale) begin
      mux_addr <= sa[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      cap_index <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        cap_index <= to_index;
        cap_addr  <= acc_addr;
        cap_data  <= bd_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      rf  <= '0;
    end else if (commit) begin
      if (cap_index)   idx <= cap_data;
      else if (cap_ok) rf[cap_addr[REG_AW-1:0]] <= cap_data;
    end
  end

  assert_pc_oe_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_oe && pc_mode) |-> (sa[9:1] == BASE_HI));
  assert_mc_oe_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_oe && !pc_mode) |-> !cs_n);
  assert_both_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_mode && !ior_n && !iow_n) |-> !bd_oe);
  assert_rf_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf != $past(rf)) |-> $past(wr_q && !wr_act));
  assert_idx_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> $past(commit && cap_index));
  assert_range_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cap_index && !cap_ok) |=> $stable(rf));
  assert_mux_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale)) |-> $stable(mux_addr));
  assert_out_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bd_oe |-> (bd_out == 8'd0));
endmodule

// File: tb/hostbus_frontend_tb.sv
module hostbus_frontend_tb_top;
  localparam logic [9:0] BASE = 10'h2E0;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [3:0] iosel = 4'b0011;
  logic ale = 0, mux_mode = 0;
  logic [9:0] sa = 0;
  logic ior_n = 1, iow_n = 1, cs_n = 1, rd_n = 1, wr_n = 1, rw = 1, ds_n = 1;
  logic [7:0] bd_in = 0;
  logic [7:0] bd_out;
  logic bd_oe;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R10";

  always #10 clk = ~clk;

  hostbus_frontend #(.BASE_ADDR(BASE), .REG_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .iosel(iosel), .ale(ale), .mux_mode(mux_mode),
    .sa(sa), .ior_n(ior_n), .iow_n(iow_n), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .rw(rw), .ds_n(ds_n), .bd_in(bd_in), .bd_out(bd_out), .bd_oe(bd_oe));

  // behavioural reference
  int m_rf[256];
  int m_idx, m_mux, p_addr, p_data;
  bit m_pend, p_index;

  function automatic bit is_pc(); return iosel != 0; endfunction
  function automatic bit hit(); return (sa >> 1) == (BASE >> 1); endfunction
  function automatic int cur_addr();
    if (is_pc()) return m_idx;
    if (mux_mode) return m_mux;
    return int'(sa[7:0]);
  endfunction
  function automatic bit m_read();
    if (is_pc()) return hit() && ior_n == 0 && iow_n == 1;
    if (cs_n) return 0;
    if (!mux_mode && ale) return ds_n == 0 && rw == 1;
    return rd_n == 0 && wr_n == 1;
  endfunction
  function automatic bit m_write();
    if (is_pc()) return hit() && iow_n == 0 && ior_n == 1;
    if (cs_n) return 0;
    if (!mux_mode && ale) return ds_n == 0 && rw == 0;
    return wr_n == 0 && rd_n == 1;
  endfunction
  function automatic int m_data();
    int a;
    if (is_pc() && sa[0]) return m_idx;
    a = cur_addr();
    return (a < (1 << AW)) ? m_rf[a] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_rf[i]) m_rf[i] = 0;
      m_idx = 0; m_mux = 0; m_pend = 0; p_addr = 0; p_data = 0; p_index = 0;
    end else begin
      bit w;
      w = m_write();
      if (m_pend && !w) begin
        if (p_index) m_idx = p_data;
        else if (p_addr < (1 << AW)) m_rf[p_addr] = p_data;
      end
      if (w) begin
        p_index = is_pc() && sa[0];
        p_addr = cur_addr();
        p_data = int'(bd_in);
      end
      m_pend = w;
      if (!is_pc() && mux_mode && ale) m_mux = int'(sa[7:0]);
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit eo; int ed;
    eo = m_read();
    ed = eo ? m_data() : 0;
    checks++;
    if (bd_oe !== eo || bd_out !== ed[7:0]) begin
      fails++;
      $display("FAIL %s cycle model: oe=%0b out=%02h expected oe=%0b out=%02h",
               tag, bd_oe, bd_out, eo, ed[7:0]);
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", t, act, exp);
    end
  endtask
  task automatic idle();
    ior_n = 1; iow_n = 1; cs_n = 1; rd_n = 1; wr_n = 1; rw = 1; ds_n = 1;
  endtask

  task automatic pc_wr(logic [9:0] a, logic [7:0] d);
    sa = a; bd_in = d; iow_n = 0; tick(); tick(); idle(); tick(); tick();
  endtask
  task automatic pc_rd(logic [9:0] a, int eoe, int exp, string t);
    sa = a; ior_n = 0; @(negedge clk);
    chk(t, bd_oe, eoe); chk(t, bd_out, exp); tick(); idle(); tick();
  endtask

  task automatic put_addr(logic [7:0] a);
    sa = {2'b00, a};
    if (mux_mode) begin ale = 1; tick(); ale = 0; end
  endtask
  task automatic mc_wr(logic [7:0] a, logic [7:0] d);
    put_addr(a); bd_in = d;
    if (mux_mode) sa[7:0] = d;
    cs_n = 0;
    if (!mux_mode && ale) begin rw = 0; ds_n = 0; end else wr_n = 0;
    tick(); tick(); idle(); tick(); tick();
  endtask
  task automatic mc_rd(logic [7:0] a, int exp, string t);
    put_addr(a); cs_n = 0;
    if (!mux_mode && ale) begin rw = 1; ds_n = 0; end else rd_n = 0;
    @(negedge clk); chk(t, bd_oe, 1); chk(t, bd_out, exp); tick(); idle(); tick();
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    tag = "R10";
    chk("R9 idle oe", bd_oe, 0);
    pc_rd(BASE | 1, 1, 8'h00, "R10 index reset");
    pc_rd(BASE, 1, 8'h00, "R10 reg0 reset");

    tag = "R3";
    pc_wr(BASE | 1, 8'h05); pc_rd(BASE | 1, 1, 8'h05, "R3 index readback");
    tag = "R4";
    pc_wr(BASE, 8'hA5);
    pc_wr(BASE | 1, 8'h0F); pc_wr(BASE, 8'h3C);
    pc_wr(BASE | 1, 8'h00); pc_wr(BASE, 8'h11);
    pc_wr(BASE | 1, 8'h05); pc_rd(BASE, 1, 8'hA5, "R4 reg5");
    pc_wr(BASE | 1, 8'h0F); pc_rd(BASE, 1, 8'h3C, "R4 reg15");

    tag = "R2";
    pc_wr(BASE + 2, 8'hFF); pc_wr(BASE + 3, 8'h02);
    pc_rd(BASE + 2, 0, 8'h00, "R2 neighbour no oe");
    pc_rd(BASE | 1, 1, 8'h0F, "R2 index untouched");
    pc_rd(BASE, 1, 8'h3C, "R2 reg15 untouched");

    tag = "R12";
    pc_wr(BASE | 1, 8'h00);
    sa = BASE; bd_in = 8'hEE; ior_n = 0; iow_n = 0; @(negedge clk);
    chk("R12 both strobes oe", bd_oe, 0); tick(); idle(); tick(); tick();
    pc_rd(BASE, 1, 8'h11, "R12 reg0 untouched");

    tag = "R11";
    pc_wr(BASE | 1, 8'h20); pc_wr(BASE, 8'h77);
    pc_rd(BASE, 1, 8'h00, "R11 pc out of range read");

    tag = "R1";
    sa = BASE; cs_n = 0; rd_n = 0; @(negedge clk);
    chk("R1 mc strobe in pc mode", bd_oe, 0); tick(); idle(); tick();

    iosel = 0; ale = 0; mux_mode = 0; tick();
    tag = "R6";
    mc_rd(8'h05, 8'hA5, "R6 reg5 via direct");
    mc_wr(8'h03, 8'h77); mc_rd(8'h03, 8'h77, "R6 reg3");
    mc_wr(8'h13, 8'h99); mc_rd(8'h03, 8'h77, "R11 direct out of range");
    mc_rd(8'h13, 8'h00, "R11 direct out of range read");
    sa = 10'h003; bd_in = 8'h01; wr_n = 0; tick(); tick(); idle(); tick(); tick();
    mc_rd(8'h03, 8'h77, "R6 cs_n high ignored");
    tag = "R1";
    sa = BASE; ior_n = 0; @(negedge clk);
    chk("R1 pc strobe in mc mode", bd_oe, 0); tick(); idle(); tick();

    tag = "R8";
    sa = 10'h002; bd_in = 8'h12; cs_n = 0; wr_n = 0; tick(); tick();
    bd_in = 8'h5A; tick(); idle(); @(negedge clk); tick(); tick();
    mc_rd(8'h02, 8'h5A, "R8 last data committed");

    tag = "R5";
    ale = 1; tick();
    mc_wr(8'h07, 8'h42); mc_rd(8'h07, 8'h42, "R5 moto reg7");
    mc_rd(8'h0F, 8'h3C, "R5 moto reg15");

    tag = "R7";
    ale = 0; mux_mode = 1; tick();
    mc_wr(8'h09, 8'hC3); mc_rd(8'h09, 8'hC3, "R7 mux reg9");
    mc_wr(8'h01, 8'h6E); mc_rd(8'h01, 8'h6E, "R7 mux reg1");
    mc_rd(8'h07, 8'h42, "R7 mux reg7");

    tag = "R9";
    tick(); @(negedge clk); chk("R9 idle out", bd_out, 0); chk("R9 idle oe", bd_oe, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule